// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Engine

This block is the control logic of a byte-wide, SRAM-style electrically erasable memory. The host drives an address, an 8-bit data word and three active-low strobes: chip select, output enable and write enable. A read returns the addressed byte. A write does not reach the storage array directly. Each write byte is placed in a page buffer. When the bus has been quiet for a load window, the whole page is committed in one long, self-timed programming cycle.

While a programming cycle runs, the block reports busy in three ways. A ready/busy pin requests a pull-down. Bit 7 of any read returns the complement of the last byte loaded. Bit 6 of a read changes from one read to the next. The storage array is a plain register array. The size of the array and of the page, and both durations in clock cycles, are parameters. For an 8K x 8 device, set `ADDR_W = 13` and `PAGE_W = 5`. The default `ADDR_W` is 11, which keeps the elaborated array small.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: The array holds 2**ADDR_W bytes. With the engine idle, a read (chip select low, output enable low, write enable high) shows the stored byte on `dq_o`, with `dq_oe_o` = 1.
- R2: `dq_oe_o` is 0 whenever chip select is high. It is also 0 whenever the read condition of R1 does not hold, for example when output enable is high or write enable is low.
- R3: A write strobe is open while write enable and chip select are both low and output enable is high. Either strobe may open or close it. The address is taken at the cycle the strobe opens. The data is the last value seen before it closes. A strobe with output enable low writes nothing.
- R4: The page is `addr[ADDR_W-1:PAGE_W]`, and the offset is `addr[PAGE_W-1:0]`. One load holds up to 2**PAGE_W bytes of the page set by its first byte. A byte aimed at any other page is ignored.
- R5: The load window reloads on each accepted byte and holds while a strobe is open. Programming starts LOAD_CYC clock cycles after the clock edge that accepts the last byte.
- R6: Programming lasts PROG_CYC clock cycles. During that time `rb_low_o` = 1 (pull the ready/busy line low). It is 0 otherwise.
- R7: During programming, a read returns three things. Bit 7 is the inverse of bit 7 of the last accepted byte. Bit 6 is 0 on the first read of the cycle and inverts after each read. Bits 5..0 are the array's current, uncommitted contents.
- R8: Write strobes that close while programming runs are ignored.
- R9: At the end of programming, only the offsets loaded in that page are written to the array. Every other location keeps its value.
- R10: The active-low reset clears the load and programming state. After reset, `rb_low_o` = 0, and a load interrupted by reset is never programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data from the bus |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| dq_o | output | 8 | Read data toward the bus |
| dq_oe_o | output | 1 | Drive enable for `dq_o`; bus released when 0 |
| rb_low_o | output | 1 | 1 requests the ready/busy line to be pulled low |

## Verification
A small configuration (256 bytes, eight 32-byte pages) is filled completely. Pages alternate between strobes closed by write enable and strobes closed by chip select. Mid-strobe changes of the address and the data show which edge captures each one. The whole array is then read back. Single-byte loads measure the exact load-window and busy durations. Reads during programming tell the polling bit, the toggling bit and the uncommitted low bits apart. Sparse loads with a stray other-page byte, writes during programming and a reset in mid-load separate loaded offsets from untouched ones.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_PROG = 2'd2
  } seq_state_e;
endpackage

// File: rtl/eep_strobe_dec.sv
module eep_strobe_dec #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_act_o,
  output logic              wr_act_o,
  output logic              wr_done_o,
  output logic              rd_end_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              wr_act_q, rd_act_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    wr_act_o  = !we_n_i && !ce_n_i && oe_n_i;
    rd_act_o  = !ce_n_i && !oe_n_i && we_n_i;
    wr_done_o = wr_act_q && !wr_act_o;
    rd_end_o  = rd_act_q && !rd_act_o;
    addr_d    = (wr_act_o && !wr_act_q) ? addr_i : addr_q;
    data_d    = wr_act_o ? data_i : data_q;
    wr_addr_o = addr_q;
    wr_data_o = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      wr_act_q <= wr_act_o;
      rd_act_q <= rd_act_o;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_d;
    data_q <= data_d;
  end

  // R3: a read and a write strobe never decode together
  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_act_o, wr_act_o}));
endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq
  import eep_pkg::*;
#(
  parameter int PG_ADDR_W = 6,
  parameter int LOAD_CYC  = 5000,
  parameter int PROG_CYC  = 250000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_done_i,
  input  logic                 wr_act_i,
  input  logic                 rd_end_i,
  input  logic [PG_ADDR_W-1:0] wr_page_i,
  output seq_state_e           state_o,
  output logic                 accept_o,
  output logic                 commit_o,
  output logic [PG_ADDR_W-1:0] page_o,
  output logic                 tog_o
);
  localparam int LT_W = $clog2(LOAD_CYC + 1);
  localparam int PT_W = $clog2(PROG_CYC + 1);
  localparam logic [LT_W-1:0] LOAD_RLD = LT_W'(LOAD_CYC - 1);
  localparam logic [PT_W-1:0] PROG_RLD = PT_W'(PROG_CYC - 1);

  seq_state_e           state_q, state_d;
  logic [LT_W-1:0]      ltim_q, ltim_d;
  logic [PT_W-1:0]      ptim_q, ptim_d;
  logic [PG_ADDR_W-1:0] page_q, page_d;
  logic                 tog_q, tog_d;

  always_comb begin
    state_d  = state_q;
    ltim_d   = ltim_q;
    ptim_d   = ptim_q;
    page_d   = page_q;
    tog_d    = tog_q;
    accept_o = wr_done_i &&
               ((state_q == SEQ_IDLE) ||
                ((state_q == SEQ_LOAD) && (wr_page_i == page_q)));
    commit_o = (state_q == SEQ_PROG) && (ptim_q == '0);
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept_o) begin
          state_d = SEQ_LOAD;
          page_d  = wr_page_i;
          ltim_d  = LOAD_RLD;
        end
      end
      SEQ_LOAD: begin
        if (accept_o || wr_act_i) begin
          ltim_d = LOAD_RLD;
        end else if (ltim_q == '0) begin
          state_d = SEQ_PROG;
          ptim_d  = PROG_RLD;
          tog_d   = 1'b0;
        end else begin
          ltim_d = ltim_q - 1'b1;
        end
      end
      SEQ_PROG: begin
        if (rd_end_i) tog_d = !tog_q;
        if (commit_o) state_d = SEQ_IDLE;
        else          ptim_d  = ptim_q - 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ltim_q  <= '0;
      ptim_q  <= '0;
      page_q  <= '0;
      tog_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ltim_q  <= ltim_d;
      ptim_q  <= ptim_d;
      page_q  <= page_d;
      tog_q   <= tog_d;
    end
  end

  assign state_o = state_q;
  assign page_o  = page_q;
  assign tog_o   = tog_q;

  // R5: programming is only ever entered from a running load window
  p_prog_from_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == SEQ_PROG) |-> ($past(state_q) == SEQ_LOAD));
  // R5: the window counter never exceeds its reload value
  p_window_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ltim_q <= LOAD_RLD);
  // R6: the busy counter never exceeds its reload value
  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptim_q <= PROG_RLD);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept_i,
  input  logic                          commit_i,
  input  logic                          busy_i,
  input  logic [PAGE_W-1:0]             offset_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic [(1<<PAGE_W)-1:0]        vmask_o,
  output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] bytes_o,
  output logic                          last_msb_o
);
  localparam int NB = 1 << PAGE_W;

  logic [NB-1:0]             vmask_q, vmask_d;
  logic [NB-1:0][DATA_W-1:0] bytes_q;
  logic                      last_msb_q, last_msb_d;

  always_comb begin
    vmask_d    = vmask_q;
    last_msb_d = last_msb_q;
    if (commit_i) begin
      vmask_d = '0;
    end else if (accept_i) begin
      vmask_d    = vmask_q | (NB'(1) << offset_i);
      last_msb_d = data_i[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmask_q    <= '0;
      last_msb_q <= 1'b0;
    end else begin
      vmask_q    <= vmask_d;
      last_msb_q <= last_msb_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept_i) bytes_q[offset_i] <= data_i;
  end

  assign vmask_o    = vmask_q;
  assign bytes_o    = bytes_q;
  assign last_msb_o = last_msb_q;

  // R8: nothing enters the buffer while a programming cycle runs
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !commit_i) |=> $stable(vmask_q));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                               clk,
  input  logic [ADDR_W-1:0]                  rd_addr_i,
  output logic [DATA_W-1:0]                  rd_data_o,
  input  logic                               commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]           page_i,
  input  logic [(1<<PAGE_W)-1:0]             vmask_i,
  input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0] bytes_i
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NB    = 1 << PAGE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_comb rd_data_o = mem[rd_addr_i];

  always_ff @(posedge clk) begin
    for (int o = 0; o < NB; o++) begin
      if (commit_i && vmask_i[o]) mem[{page_i, PAGE_W'(o)}] <= bytes_i[o];
    end
  end
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 5,
  parameter int DATA_W   = 8,
  parameter int LOAD_CYC = 5000,
  parameter int PROG_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              rb_low_o
);
  localparam int PG_ADDR_W = ADDR_W - PAGE_W;
  localparam int NB        = 1 << PAGE_W;

  logic                      rd_act, wr_act, wr_done, rd_end;
  logic [ADDR_W-1:0]         wr_addr;
  logic [DATA_W-1:0]         wr_data, arr_data;
  seq_state_e                state;
  logic                      accept, commit, tog, last_msb, busy;
  logic [PG_ADDR_W-1:0]      page;
  logic [NB-1:0]             vmask;
  logic [NB-1:0][DATA_W-1:0] pbytes;

  eep_strobe_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
    .we_n_i(we_n_i), .addr_i(addr_i), .data_i(data_i),
    .rd_act_o(rd_act), .wr_act_o(wr_act), .wr_done_o(wr_done),
    .rd_end_o(rd_end), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  eep_prog_seq #(.PG_ADDR_W(PG_ADDR_W), .LOAD_CYC(LOAD_CYC),
                 .PROG_CYC(PROG_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .wr_done_i(wr_done), .wr_act_i(wr_act),
    .rd_end_i(rd_end), .wr_page_i(wr_addr[ADDR_W-1:PAGE_W]),
    .state_o(state), .accept_o(accept), .commit_o(commit),
    .page_o(page), .tog_o(tog));

  assign busy = (state == SEQ_PROG);

  eep_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .commit_i(commit),
    .busy_i(busy), .offset_i(wr_addr[PAGE_W-1:0]), .data_i(wr_data),
    .vmask_o(vmask), .bytes_o(pbytes), .last_msb_o(last_msb));

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) arr_i (
    .clk(clk), .rd_addr_i(addr_i), .rd_data_o(arr_data),
    .commit_i(commit), .page_i(page), .vmask_i(vmask), .bytes_i(pbytes));

  always_comb begin
    if (busy) dq_o = {!last_msb, tog, arr_data[DATA_W-3:0]};
    else      dq_o = arr_data;
    dq_oe_o  = rd_act;
    rb_low_o = busy;
  end

  // R2: bus released whenever chip select is high
  p_bus_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_i |-> !dq_oe_o);
  // R4: a running load window always holds at least one loaded byte
  p_load_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_LOAD) |-> (vmask != '0));
  // R9: the buffer is emptied once programming ends
  p_commit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (vmask == '0) && !rb_low_o);
endmodule

// File: tb/eeprom_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_ctrl_tb_top;
  localparam int AW = 8;
  localparam int PW = 5;
  localparam int LC = 12;
  localparam int PC = 60;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic [7:0]    data_i;
  logic          ce_n_i, oe_n_i, we_n_i;
  logic [7:0]    dq_o;
  logic          dq_oe_o, rb_low_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] exp_mem [256];

  always #5 clk = !clk;

  eeprom_page_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(8),
                     .LOAD_CYC(LC), .PROG_CYC(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .data_i(data_i),
    .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .rb_low_o(rb_low_o));

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // write strobe; ce_ctrl selects chip select as the opening/closing strobe
  task automatic wr_byte(input int a, input logic [7:0] d, input bit ce_ctrl);
    addr_i = AW'(a); data_i = ~d; oe_n_i = 1'b1;
    if (ce_ctrl) we_n_i = 1'b0; else ce_n_i = 1'b0;
    @(negedge clk);
    if (ce_ctrl) ce_n_i = 1'b0; else we_n_i = 1'b0;
    @(negedge clk);
    addr_i = ~AW'(a); data_i = d;
    @(negedge clk);
    if (ce_ctrl) ce_n_i = 1'b1; else we_n_i = 1'b1;
    @(negedge clk);
    if (ce_ctrl) we_n_i = 1'b1; else ce_n_i = 1'b1;
  endtask

  task automatic rd_byte(input int a, output logic [7:0] d, output logic oe);
    addr_i = AW'(a); ce_n_i = 1'b0; oe_n_i = 1'b0; we_n_i = 1'b1;
    @(negedge clk);
    d = dq_o; oe = dq_oe_o;
    ce_n_i = 1'b1; oe_n_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_done();
    int k = 0;
    while (!rb_low_o && k < 1000) begin @(negedge clk); k++; end
    while (rb_low_o && k < 2000) begin @(negedge clk); k++; end
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    logic       oe;
    int         k;
    int         n;
    rst_n = 1'b0; ce_n_i = 1'b1; oe_n_i = 1'b1; we_n_i = 1'b1;
    addr_i = '0; data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset busy", 32'(rb_low_o), 0);
    chk("R2 reset bus", 32'(dq_oe_o), 0);

    // fill every page, alternating the closing strobe (R3, R4)
    for (int p = 0; p < 8; p++) begin
      for (int o = 0; o < 32; o++) wr_byte(p * 32 + o, pat(p * 32 + o), p[0]);
      wait_done();
      for (int o = 0; o < 32; o++) exp_mem[p * 32 + o] = pat(p * 32 + o);
    end
    for (int a = 0; a < 256; a++) begin
      rd_byte(a, d, oe);
      chk("R1/R3 readback", 32'(d), 32'(exp_mem[a]));
      if (a == 0) chk("R1 drive", 32'(oe), 1);
    end

    // bus release cases and a strobe with output enable low (R2, R3)
    ce_n_i = 1'b1; oe_n_i = 1'b0; we_n_i = 1'b1; @(negedge clk);
    chk("R2 ce high", 32'(dq_oe_o), 0);
    ce_n_i = 1'b0; oe_n_i = 1'b1; @(negedge clk);
    chk("R2 oe high", 32'(dq_oe_o), 0);
    addr_i = 8'd10; data_i = 8'h00;
    oe_n_i = 1'b0; we_n_i = 1'b0; @(negedge clk);
    chk("R2 we low", 32'(dq_oe_o), 0);
    @(negedge clk); we_n_i = 1'b1; ce_n_i = 1'b1; oe_n_i = 1'b1;
    repeat (LC + 4) @(negedge clk);
    chk("R3 oe low no write", 32'(rb_low_o), 0);
    rd_byte(10, d, oe);
    chk("R3 oe low data", 32'(d), 32'(exp_mem[10]));

    // load window, polling, toggle and ignored busy write (R5, R7, R8)
    wr_byte(67, 8'hC5, 1'b0);
    k = 1;
    while (!rb_low_o && k < 100) begin @(negedge clk); k++; end
    chk("R5 window", k, LC + 1);
    for (int r = 0; r < 3; r++) begin
      rd_byte(67, d, oe);
      chk("R7 poll read", 32'(d), 32'({1'b0, r[0], exp_mem[67][5:0]}));
    end
    chk("R6 busy during prog", 32'(rb_low_o), 1);
    wr_byte(68, 8'h5A, 1'b0);
    wait_done();
    exp_mem[67] = 8'hC5;
    rd_byte(67, d, oe); chk("R9 loaded byte", 32'(d), 32'h0C5);
    rd_byte(68, d, oe); chk("R8 busy write ignored", 32'(d), 32'(exp_mem[68]));
    rd_byte(66, d, oe); chk("R9 neighbour", 32'(d), 32'(exp_mem[66]));
    repeat (LC + 4) @(negedge clk);
    chk("R8 no later prog", 32'(rb_low_o), 0);

    // programming duration with a chip-select controlled byte (R6)
    wr_byte(100, 8'h33, 1'b1);
    k = 1;
    while (!rb_low_o && k < 100) begin @(negedge clk); k++; end
    chk("R5 window ce", k, LC + 1);
    n = 0;
    while (rb_low_o && n < 500) begin n++; @(negedge clk); end
    chk("R6 busy length", n, PC);
    exp_mem[100] = 8'h33;
    @(negedge clk);
    rd_byte(100, d, oe); chk("R6 committed", 32'(d), 32'h33);

    // sparse load plus a stray other-page byte (R4, R9)
    for (int o = 0; o < 32; o += 2) wr_byte(160 + o, ~pat(160 + o), o[1]);
    wr_byte(193, 8'hEE, 1'b0);
    wait_done();
    for (int o = 0; o < 32; o += 2) exp_mem[160 + o] = ~pat(160 + o);
    for (int a = 160; a < 224; a++) begin
      rd_byte(a, d, oe);
      chk("R4/R9 sparse page", 32'(d), 32'(exp_mem[a]));
    end

    // reset during a load: never programmed (R10)
    wr_byte(20, 8'h99, 1'b0);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    k = 0;
    for (int c = 0; c < LC + PC + 10; c++) begin
      @(negedge clk);
      if (rb_low_o) k++;
    end
    chk("R10 no prog after reset", k, 0);
    rd_byte(20, d, oe); chk("R10 data kept", 32'(d), 32'(exp_mem[20]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule